// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, per incoming Ethernet frame, whether the frame is kept or thrown away based on its 48-bit destination address. The receive path presents the first six bytes of the frame one byte per accepted beat, with a start-of-frame strobe on the first of them. The filter compares the address against a single programmed station address. It also holds two 64-bit hash tables, one consulted for individual (unicast) addresses and one for group (multicast) addresses. It applies a configurable broadcast policy and an override that accepts everything. No bus cycles are spent on rejected frames: the verdict goes straight to the receive FIFO's flush logic.

The verdict appears one clock after the sixth address byte and is held until the next start-of-frame strobe. Besides the accept bit, a match-kind code reports which rule fired. A frame that ends before its address is complete is rejected as a runt fragment.

Top module: `rx_dest_filter`

## Requirements
- R1: Out of reset, `verdict_vld`, `accept` and `match_kind` are all 0.
- R2: Address byte k (k = 0 for the first byte after start-of-frame) is compared with `station_addr[8k+7:8k]`. An individual address equal to the station address is accepted with `match_kind` = 1 (exact). Any single-bit difference fails the exact match.
- R3: An individual address (bit 0 of byte 0 is 0) that fails the exact match is accepted with `match_kind` = 2 if bit `idx` of `uni_hash_tbl` is 1. Otherwise it is rejected with `match_kind` = 0.
- R4: The hash index `idx` is bits 31..26 of a CRC-32 register. The register starts at all ones and takes all six address bytes, each byte least significant bit first, with polynomial 0x04C11DB7: for each bit d, fb = crc[31] ^ d, and crc = (crc << 1) ^ (fb ? poly : 0). No final inversion is applied.
- R5: A group address (bit 0 of byte 0 is 1) other than broadcast is accepted with `match_kind` = 3 when bit `idx` of `grp_hash_tbl` is 1. Otherwise it is rejected. `uni_hash_tbl` has no effect on group addresses.
- R6: The broadcast address (all 48 bits one) is accepted with `match_kind` = 4 when `bcast_reject` is 0. When `bcast_reject` is 1 it is rejected with `match_kind` = 0, whatever `grp_hash_tbl` holds.
- R7: With `promisc` = 1, a complete address that no other rule accepts is accepted with `match_kind` = 5. An address that another rule accepts keeps that rule's code.
- R8: `verdict_vld` is 0 while address bytes arrive. It rises in the cycle after the clock edge that takes the sixth byte.
- R9: The verdict is held unchanged, even if the configuration inputs change, until a start-of-frame strobe. A start-of-frame strobe clears `verdict_vld` in the next cycle.
- R10: `frame_end` before the sixth byte gives `verdict_vld` = 1, `accept` = 0 and `match_kind` = 0 in the next cycle, even with `promisc` = 1.
- R11: Bytes and `frame_end` that arrive while no frame is being collected have no effect. This covers input before any start-of-frame after reset and input after a verdict.
- R12: An exact station match is reported as `match_kind` = 1 even when the unicast hash bit for that address is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame strobe; restarts address collection |
| byte_vld | input | 1 | `byte_data` carries a frame byte this cycle |
| byte_data | input | 8 | Received frame byte |
| frame_end | input | 1 | Frame terminated this cycle |
| station_addr | input | 48 | Station address; byte k in bits 8k+7..8k |
| uni_hash_tbl | input | 64 | Hash table for individual addresses |
| grp_hash_tbl | input | 64 | Hash table for group addresses |
| bcast_reject | input | 1 | 1: reject broadcast frames; 0: accept them |
| promisc | input | 1 | Accept every complete address |
| verdict_vld | output | 1 | Verdict available and held |
| accept | output | 1 | 1: keep frame; 0: flush it |
| match_kind | output | 3 | 0 none, 1 exact, 2 unicast hash, 3 multicast hash, 4 broadcast, 5 promiscuous |

## Verification
The bench builds the filter with its default parameters: six address bytes, 6-bit hash index, and the incremental per-byte comparison variant. With a 64-entry table, every table position can be reached. For each of the 64 index values, the bench searches for a unicast and a multicast address that hash there. It then drives each address against a table with only that bit set and against a table with only that bit clear, so every table position is exercised in both polarities. It also flips each of the 48 station address bits in turn, and delivers runts of every length from one to five bytes.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

   typedef enum logic [2:0] {
      MK_NONE    = 3'd0,
      MK_EXACT   = 3'd1,
      MK_UHASH   = 3'd2,
      MK_MHASH   = 3'd3,
      MK_BCAST   = 3'd4,
      MK_PROMISC = 3'd5
   } match_kind_e;

   // Advance a CRC-32 register by one byte, least significant bit first.
   function automatic logic [31:0] crc_feed_byte(input logic [31:0] crc_in,
                                                 input logic [7:0]  din,
                                                 input logic [31:0] poly);
      logic [31:0] c;
      logic        fb;
      c = crc_in;
      for (int b = 0; b < 8; b++) begin
         fb = c[31] ^ din[b];
         c  = {c[30:0], 1'b0} ^ (fb ? poly : 32'h0);
      end
      return c;
   endfunction

endpackage

// File: rtl/rdf_byte_track.sv
module rdf_byte_track #(
   parameter int          ADDR_BYTES = 6,
   parameter logic [31:0] CRC_POLY   = 32'h04C1_1DB7,
   parameter bit          INCR_MATCH = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sof,
   input  logic                    byte_vld,
   input  logic [7:0]              byte_data,
   input  logic                    frame_end,
   input  logic [8*ADDR_BYTES-1:0] station_addr,
   output logic                    last_take,
   output logic                    runt_take,
   output logic [31:0]             crc_nxt,
   output logic                    exact_hit,
   output logic                    all_ones,
   output logic                    group_bit
);

   localparam int AW    = 8 * ADDR_BYTES;
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);
   localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_base;
   logic [IDX_W-1:0] lane_idx;
   logic             active_q;
   logic             act_eff;
   logic             take;
   logic             first_lane;
   logic [31:0]      crc_q;
   logic [31:0]      crc_base;
   logic             grp_q;

   always_comb begin
      cnt_base   = sof ? '0 : cnt_q;
      act_eff    = sof | active_q;
      take       = byte_vld & act_eff;
      first_lane = (cnt_base == '0);
      last_take  = take & (cnt_base == CNT_W'(ADDR_BYTES - 1));
      runt_take  = frame_end & act_eff & ~last_take;
      lane_idx   = (cnt_base >= CNT_W'(ADDR_BYTES)) ? '0 : IDX_W'(cnt_base);
      crc_base   = sof ? 32'hFFFF_FFFF : crc_q;
      crc_nxt    = rdf_pkg::crc_feed_byte(crc_base, byte_data, CRC_POLY);
      group_bit  = first_lane ? byte_data[0] : grp_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         crc_q    <= 32'hFFFF_FFFF;
         grp_q    <= 1'b0;
      end else begin
         if (sof | take) begin
            cnt_q <= take ? cnt_base + 1'b1 : '0;
            crc_q <= take ? crc_nxt : 32'hFFFF_FFFF;
         end
         if (take && first_lane)
            grp_q <= byte_data[0];
         if (last_take | runt_take)
            active_q <= 1'b0;
         else if (sof)
            active_q <= 1'b1;
      end
   end

   generate
      if (INCR_MATCH) begin : g_incr
         // Running per-byte comparison: two flags instead of an address store.
         logic       eq_q, ones_q;
         logic       eq_base, ones_base;
         logic [7:0] lane_station;
         logic       eq_now, ones_now;

         always_comb begin
            lane_station = station_addr[8*lane_idx +: 8];
            eq_base      = first_lane ? 1'b1 : eq_q;
            ones_base    = first_lane ? 1'b1 : ones_q;
            eq_now       = eq_base & (byte_data == lane_station);
            ones_now     = ones_base & (&byte_data);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               eq_q   <= 1'b0;
               ones_q <= 1'b0;
            end else if (take) begin
               eq_q   <= eq_now;
               ones_q <= ones_now;
            end
         end

         assign exact_hit = eq_now;
         assign all_ones  = ones_now;
      end else begin : g_full
         // Store the leading bytes and compare the full word at the last byte.
         logic [AW-9:0] addr_q;
         logic [AW-1:0] addr_full;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q <= '0;
            end else begin
               for (int i = 0; i < ADDR_BYTES - 1; i++) begin
                  if (take && (lane_idx == IDX_W'(i)))
                     addr_q[8*i +: 8] <= byte_data;
               end
            end
         end

         assign addr_full = {byte_data, addr_q};
         assign exact_hit = (addr_full == station_addr);
         assign all_ones  = &addr_full;
      end
   endgenerate

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(ADDR_BYTES));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !sof) |=> !active_q);

   // R8
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> (cnt_q <= CNT_W'(1)));

endmodule

// File: rtl/rdf_hash_pick.sv
module rdf_hash_pick #(
   parameter int HASH_BITS = 6,
   localparam int TBL_SIZE = 1 << HASH_BITS
) (
   input  logic [31:0]         crc,
   input  logic [TBL_SIZE-1:0] tbl,
   output logic                hit
);

   logic [HASH_BITS-1:0] idx;

   assign idx = crc[31 -: HASH_BITS];
   assign hit = tbl[idx];

endmodule

// File: rtl/rdf_rule_eval.sv
module rdf_rule_eval
   import rdf_pkg::*;
(
   input  logic        exact_hit,
   input  logic        all_ones,
   input  logic        group_bit,
   input  logic        uni_hit,
   input  logic        grp_hit,
   input  logic        bcast_reject,
   input  logic        promisc,
   output logic        accept,
   output match_kind_e kind
);

   always_comb begin
      kind = MK_NONE;
      if (group_bit) begin
         if (all_ones)
            kind = bcast_reject ? MK_NONE : MK_BCAST;
         else if (grp_hit)
            kind = MK_MHASH;
      end else begin
         if (exact_hit)
            kind = MK_EXACT;
         else if (uni_hit)
            kind = MK_UHASH;
      end
      if ((kind == MK_NONE) && promisc)
         kind = MK_PROMISC;
      accept = (kind != MK_NONE);
   end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
   parameter int          ADDR_BYTES = 6,
   parameter int          HASH_BITS  = 6,
   parameter logic [31:0] CRC_POLY   = 32'h04C1_1DB7,
   parameter bit          INCR_MATCH = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sof,
   input  logic                      byte_vld,
   input  logic [7:0]                byte_data,
   input  logic                      frame_end,
   input  logic [8*ADDR_BYTES-1:0]   station_addr,
   input  logic [(1<<HASH_BITS)-1:0] uni_hash_tbl,
   input  logic [(1<<HASH_BITS)-1:0] grp_hash_tbl,
   input  logic                      bcast_reject,
   input  logic                      promisc,
   output logic                      verdict_vld,
   output logic                      accept,
   output logic [2:0]                match_kind
);
   import rdf_pkg::*;

   generate
      if (ADDR_BYTES < 2) begin : g_bad_bytes
         $error("ADDR_BYTES must be at least 2");
      end
      if ((HASH_BITS < 1) || (HASH_BITS > 10)) begin : g_bad_hash
         $error("HASH_BITS must lie in 1..10");
      end
   endgenerate

   logic        last_take, runt_take;
   logic [31:0] crc_nxt;
   logic        exact_hit, all_ones, group_bit;
   logic        uni_hit, grp_hit;
   logic        dec_accept;
   match_kind_e dec_kind;

   logic        vld_q, acc_q;
   match_kind_e kind_q;

   rdf_byte_track #(
      .ADDR_BYTES (ADDR_BYTES),
      .CRC_POLY   (CRC_POLY),
      .INCR_MATCH (INCR_MATCH)
   ) track_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof          (sof),
      .byte_vld     (byte_vld),
      .byte_data    (byte_data),
      .frame_end    (frame_end),
      .station_addr (station_addr),
      .last_take    (last_take),
      .runt_take    (runt_take),
      .crc_nxt      (crc_nxt),
      .exact_hit    (exact_hit),
      .all_ones     (all_ones),
      .group_bit    (group_bit)
   );

   rdf_hash_pick #(.HASH_BITS(HASH_BITS)) uni_pick_i (
      .crc (crc_nxt),
      .tbl (uni_hash_tbl),
      .hit (uni_hit)
   );

   rdf_hash_pick #(.HASH_BITS(HASH_BITS)) grp_pick_i (
      .crc (crc_nxt),
      .tbl (grp_hash_tbl),
      .hit (grp_hit)
   );

   rdf_rule_eval eval_i (
      .exact_hit    (exact_hit),
      .all_ones     (all_ones),
      .group_bit    (group_bit),
      .uni_hit      (uni_hit),
      .grp_hit      (grp_hit),
      .bcast_reject (bcast_reject),
      .promisc      (promisc),
      .accept       (dec_accept),
      .kind         (dec_kind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         acc_q  <= 1'b0;
         kind_q <= MK_NONE;
      end else if (last_take) begin
         vld_q  <= 1'b1;
         acc_q  <= dec_accept;
         kind_q <= dec_kind;
      end else if (runt_take) begin
         vld_q  <= 1'b1;
         acc_q  <= 1'b0;
         kind_q <= MK_NONE;
      end else if (sof) begin
         vld_q  <= 1'b0;
         acc_q  <= 1'b0;
         kind_q <= MK_NONE;
      end
   end

   assign verdict_vld = vld_q;
   assign accept      = acc_q;
   assign match_kind  = kind_q;

   // R8
   verdict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_q) |-> $past(last_take || runt_take));

   // R9
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !sof) |=> (vld_q && $stable(acc_q) && $stable(kind_q)));

   // R10
   reject_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !acc_q) |-> (kind_q == MK_NONE));

   // R7
   promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_take && promisc) |=> acc_q);

   // R6
   bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_take && group_bit && all_ones && bcast_reject && !promisc) |=> !acc_q);

   // R10
   runt_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      runt_take |=> (vld_q && !acc_q));

endmodule

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;

   localparam int          AB   = 6;
   localparam int          HB   = 6;
   localparam int          TBL  = 1 << HB;
   localparam logic [31:0] POLY = 32'h04C1_1DB7;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sof = 1'b0, byte_vld = 1'b0, frame_end = 1'b0;
   logic [7:0]     byte_data = '0;
   logic [47:0]    station = 48'h6655_4433_2210;
   logic [TBL-1:0] uni_tbl = '0, grp_tbl = '0;
   logic           bc_rej = 1'b0, prom = 1'b0;
   logic           verdict_vld, accept;
   logic [2:0]     match_kind;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rx_dest_filter dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sof          (sof),
      .byte_vld     (byte_vld),
      .byte_data    (byte_data),
      .frame_end    (frame_end),
      .station_addr (station),
      .uni_hash_tbl (uni_tbl),
      .grp_hash_tbl (grp_tbl),
      .bcast_reject (bc_rej),
      .promisc      (prom),
      .verdict_vld  (verdict_vld),
      .accept       (accept),
      .match_kind   (match_kind)
   );

   task automatic chk3(string tag, logic ev, logic ea, logic [2:0] ek);
      n_run++;
      if (verdict_vld !== ev || accept !== ea || match_kind !== ek) begin
         n_fail++;
         $display("FAIL %s: vld=%0d acc=%0d kind=%0d expected vld=%0d acc=%0d kind=%0d",
                  tag, verdict_vld, accept, match_kind, ev, ea, ek);
      end
   endtask

   function automatic logic [HB-1:0] hidx(logic [47:0] a);
      logic [31:0] c;
      logic        fb;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         fb = c[31] ^ a[i];
         c  = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
      end
      return c[31 -: HB];
   endfunction

   function automatic logic [2:0] model_kind(logic [47:0] a);
      logic [2:0] k;
      k = 3'd0;
      if (a[0]) begin
         if (a == 48'hFFFF_FFFF_FFFF) k = bc_rej ? 3'd0 : 3'd4;
         else if (grp_tbl[hidx(a)])   k = 3'd3;
      end else begin
         if (a == station)            k = 3'd1;
         else if (uni_tbl[hidx(a)])   k = 3'd2;
      end
      if (k == 3'd0 && prom) k = 3'd5;
      return k;
   endfunction

   function automatic logic [47:0] find_addr(int t, bit grp);
      logic [47:0] cand;
      cand = 48'h0;
      for (int j = 0; j < 200000; j++) begin
         cand = {32'h2468_ACE1 + 32'(j) * 32'h0100_0193, 16'(j * 2) | 16'(grp)};
         if (int'(hidx(cand)) == t && cand != station) return cand;
      end
      return cand;
   endfunction

   // Drive n bytes of address a; the first carries sof.
   task automatic drive_bytes(logic [47:0] a, int n, bit use_sof);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (k == AB - 1 && use_sof) chk3("R8 low before sixth byte", 1'b0, 1'b0, 3'd0);
         sof       = use_sof && (k == 0);
         byte_vld  = 1'b1;
         byte_data = a[8*k +: 8];
      end
      @(negedge clk);
      sof      = 1'b0;
      byte_vld = 1'b0;
   endtask

   task automatic frame_check(string tag, logic [47:0] a);
      logic [2:0] ek;
      ek = model_kind(a);
      drive_bytes(a, AB, 1'b1);
      chk3(tag, 1'b1, ek != 3'd0, ek);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [47:0] a;
      repeat (3) @(negedge clk);
      chk3("R1 reset state", 1'b0, 1'b0, 3'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk3("R1 after reset release", 1'b0, 1'b0, 3'd0);

      // R11: bytes and frame_end before any sof
      prom = 1'b1;
      drive_bytes(station, AB, 1'b0);
      chk3("R11 bytes without sof", 1'b0, 1'b0, 3'd0);
      @(negedge clk) frame_end = 1'b1;
      @(negedge clk) frame_end = 1'b0;
      chk3("R11 frame_end without sof", 1'b0, 1'b0, 3'd0);
      prom = 1'b0;

      // R2 exact match, R12 priority over hash
      frame_check("R2 exact station", station);
      uni_tbl = '1;
      frame_check("R12 exact beats hash", station);
      uni_tbl = '0;
      for (int b = 0; b < 48; b++)
         frame_check("R2 single-bit miss", station ^ (48'h1 << b));

      // R3 R4 unicast hash, every table position both polarities
      for (int t = 0; t < TBL; t++) begin
         a = find_addr(t, 1'b0);
         uni_tbl = '0; uni_tbl[t] = 1'b1;
         frame_check("R3 R4 uni bit set", a);
         uni_tbl = '1; uni_tbl[t] = 1'b0;
         frame_check("R3 R4 uni bit clear", a);
      end
      uni_tbl = '0;

      // R5 multicast hash, unicast table ignored for group addresses
      for (int t = 0; t < TBL; t++) begin
         a = find_addr(t, 1'b1);
         grp_tbl = '0; grp_tbl[t] = 1'b1;
         frame_check("R5 grp bit set", a);
         grp_tbl = '1; grp_tbl[t] = 1'b0;
         uni_tbl = '1;
         frame_check("R5 grp bit clear, uni table full", a);
         uni_tbl = '0;
      end

      // R6 broadcast policy
      grp_tbl = '1;
      bc_rej  = 1'b0;
      frame_check("R6 broadcast accepted", 48'hFFFF_FFFF_FFFF);
      bc_rej  = 1'b1;
      frame_check("R6 broadcast rejected", 48'hFFFF_FFFF_FFFF);
      grp_tbl = '0;

      // R7 promiscuous override
      prom = 1'b1;
      frame_check("R7 promisc on broadcast reject", 48'hFFFF_FFFF_FFFF);
      frame_check("R7 promisc on unicast miss", station ^ 48'h0100);
      frame_check("R7 promisc keeps exact code", station);
      prom   = 1'b0;
      bc_rej = 1'b0;

      // R9 hold against configuration changes, and R11 input after verdict
      frame_check("R9 setup", station ^ 48'h2);
      station = 48'h0;
      uni_tbl = '1; grp_tbl = '1; prom = 1'b1; bc_rej = 1'b1;
      repeat (3) @(negedge clk);
      chk3("R9 held after config change", 1'b1, 1'b0, 3'd0);
      drive_bytes(48'h1234_5678_9AB0, AB, 1'b0);
      chk3("R11 bytes after verdict", 1'b1, 1'b0, 3'd0);
      @(negedge clk) frame_end = 1'b1;
      @(negedge clk) frame_end = 1'b0;
      chk3("R11 frame_end after verdict", 1'b1, 1'b0, 3'd0);
      @(negedge clk) sof = 1'b1;
      @(negedge clk) sof = 1'b0;
      chk3("R9 sof clears verdict", 1'b0, 1'b0, 3'd0);
      station = 48'h6655_4433_2210;
      uni_tbl = '0; grp_tbl = '0; bc_rej = 1'b0;

      // R10 runts of every short length, promisc left on
      for (int n = 1; n < AB; n++) begin
         drive_bytes(station, n, 1'b1);
         chk3("R10 no verdict before end", 1'b0, 1'b0, 3'd0);
         @(negedge clk) frame_end = 1'b1;
         @(negedge clk) frame_end = 1'b0;
         chk3("R10 runt rejected", 1'b1, 1'b0, 3'd0);
      end
      prom = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule